// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block generates the word address for every beat of a four-beat burst. An access begins when one of two active-low address strobes is sampled low while the load enable, which is already qualified by chip select, is high. At that clock rise the block captures a 16-bit start address. On later cycles it produces the current array address. The upper fourteen bits stay equal to the captured value. The lower two bits come from a wraparound counter that moves one position on each cycle in which the active-low advance input is sampled low.

Two burst orders are available and the mode input chooses between them:

- **Interleaved order (mode high):** each address is the captured low bits XORed with the beat index.
- **Linear order (mode low):** each address is the captured low bits plus the beat index, modulo four.

The processor strobe has priority over the controller strobe. The processor strobe is also gated by the first active-low chip enable.

The output is a combinational function of the captured start address, the burst position and the present level of the mode input. It therefore changes one clock after a load or an advance.

Top module: `burst_addr_seq`

## Requirements
- R1: With the load enable high, the first chip enable low and the processor strobe low at a clock rise, the output equals the address input from the next cycle on. That first beat is burst position 0.
- R2: With the load enable high, the controller strobe low and the processor strobe high at a clock rise, the address is captured in the same way as in R1.
- R3: When both strobes are low, only the processor strobe is recognized. If the processor strobe is then disqualified because the first chip enable is high, no load occurs, even though the controller strobe is low.
- R4: The processor strobe has no effect when the first chip enable is high. The output keeps following the current burst.
- R5: With the load enable low, neither strobe loads an address.
- R6: With no load, advance sampled low moves the burst position one step. Advance sampled high holds the output unchanged, which suspends the burst.
- R7: With mode high (interleaved order), the output low bits are the start low bits XOR the position. From start 01 the sequence is 01, 00, 11, 10.
- R8: With mode low (linear order), the output low bits are the start low bits plus the position, modulo 4. From start 01 the sequence is 01, 10, 11, 00.
- R9: After four advances the position wraps back to the start address. Output bits 15:2 never change during a burst.
- R10: In a cycle where a load occurs, the advance input has no effect. The next output is the new start address.
- R11: A synchronous reset, sampled high at a clock rise, clears the captured address and the position, so the output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstSync | input | 1 | Synchronous reset, active high |
| procStrobeN | input | 1 | Processor address strobe, active low, highest priority |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| chipEnFirstN | input | 1 | First chip enable, active low; gates the processor strobe |
| selValid | input | 1 | Load enable already qualified by chip select, active high |
| advanceN | input | 1 | Advance burst position, active low |
| modeInterleave | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addrIn | input | 16 | Start address bus |
| arrayAddr | output | 16 | Current array word address |

## Verification
The reference model is exercised with bursts from odd and even start addresses in both orders. This separates XOR sequencing from modulo-four addition, because the two orders agree only at some beats. Sequences with gaps in the advance input separate a suspended burst from a stepping one. Runs of more than four advances expose wrap faults and any carry into the upper bits. Strobe combinations cover each strobe alone, both together, the gated processor strobe and a low load enable. These show whether the priority, the gating and the qualification are correct. Loads with advance low show whether the load takes precedence, and a reset in the middle of a burst confirms that all state clears.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       procStrobeN,
  input  logic       ctrlStrobeN,
  input  logic       chipEnFirstN,
  input  logic       selValid,
  input  logic       advanceN,
  output seqStrobe_t strobes
);
  logic procHit;
  logic ctrlHit;

  always_comb begin
    // processor strobe is gated by the first chip enable
    procHit = selValid && !procStrobeN && !chipEnFirstN;
    // controller strobe only counts when the processor strobe is idle
    ctrlHit = selValid && !ctrlStrobeN && procStrobeN;
    strobes.load = procHit || ctrlHit;
    strobes.step = !advanceN && !strobes.load;
  end
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstSync,
  input  seqStrobe_t        strobes,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [UPPER_W-1:0] upperReg;
  logic [CNT_W-1:0]   startLow;
  logic [CNT_W-1:0]   burstPos;
  logic [CNT_W-1:0]   xorLow;
  logic [CNT_W-1:0]   linLow;
  logic [CNT_W-1:0]   outLow;

  always_ff @(posedge clk) begin
    if (rstSync) begin
      upperReg <= '0;
      startLow <= '0;
      burstPos <= '0;
    end else if (strobes.load) begin
      upperReg <= addrIn[ADDR_W-1:CNT_W];
      startLow <= addrIn[CNT_W-1:0];
      burstPos <= '0;
    end else if (strobes.step) begin
      burstPos <= burstPos + CNT_W'(1);
    end
  end

  for (genvar b = 0; b < CNT_W; b++) begin : gXorLane
    assign xorLow[b] = startLow[b] ^ burstPos[b];
  end

  assign linLow = startLow + burstPos;

  always_comb begin
    outLow = modeInterleave ? xorLow : linLow;
  end

  assign arrayAddr = {upperReg, outLow};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstSync,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipEnFirstN,
  input  logic              selValid,
  input  logic              advanceN,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr
);
  seqStrobe_t strobes;

  burst_seq_ctrl i_ctrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .chipEnFirstN(chipEnFirstN),
    .selValid    (selValid),
    .advanceN    (advanceN),
    .strobes     (strobes)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dp (
    .clk           (clk),
    .rstSync       (rstSync),
    .strobes       (strobes),
    .modeInterleave(modeInterleave),
    .addrIn        (addrIn),
    .arrayAddr     (arrayAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstSync,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              chipEnFirstN,
  input logic              selValid,
  input logic              advanceN,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] arrayAddr
);
  logic loadNow;
  assign loadNow = selValid &&
                   ((!procStrobeN && !chipEnFirstN) || (!ctrlStrobeN && procStrobeN));

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rstSync)
    loadNow |=> (modeInterleave != 1'b0 || modeInterleave == 1'b0) && arrayAddr == $past(addrIn)); // R1

  AST_LOAD_OVER_ADVANCE: assert property (@(posedge clk) disable iff (rstSync)
    (loadNow && !advanceN) |=> arrayAddr == $past(addrIn)); // R10

  AST_HOLD_SUSPEND: assert property (@(posedge clk) disable iff (rstSync)
    (!loadNow && advanceN) |=> ($stable(modeInterleave) -> $stable(arrayAddr))); // R6

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (rstSync)
    (!procStrobeN && chipEnFirstN && advanceN) |=> ($stable(modeInterleave) -> $stable(arrayAddr))); // R4

  AST_NO_LOAD_UNSELECTED: assert property (@(posedge clk) disable iff (rstSync)
    (!selValid && advanceN) |=> ($stable(modeInterleave) -> $stable(arrayAddr))); // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rstSync)
    !loadNow |=> arrayAddr[ADDR_W-1:CNT_W] == $past(arrayAddr[ADDR_W-1:CNT_W])); // R9

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rstSync)
    (!loadNow && !advanceN && !modeInterleave) |=>
      (modeInterleave || arrayAddr[CNT_W-1:0] == CNT_W'($past(arrayAddr[CNT_W-1:0]) + CNT_W'(1)))); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk           (clk),
  .rstSync       (rstSync),
  .procStrobeN   (procStrobeN),
  .ctrlStrobeN   (ctrlStrobeN),
  .chipEnFirstN  (chipEnFirstN),
  .selValid      (selValid),
  .advanceN      (advanceN),
  .modeInterleave(modeInterleave),
  .addrIn        (addrIn),
  .arrayAddr     (arrayAddr)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rstSync = 1'b1;
  logic        procStrobeN = 1'b1;
  logic        ctrlStrobeN = 1'b1;
  logic        chipEnFirstN = 1'b1;
  logic        selValid = 1'b0;
  logic        advanceN = 1'b1;
  logic        modeInterleave = 1'b1;
  logic [15:0] addrIn = 16'h0000;
  logic [15:0] arrayAddr;

  int errors = 0;
  int checks = 0;
  int refStart = 0;
  int refPos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk           (clk),
    .rstSync       (rstSync),
    .procStrobeN   (procStrobeN),
    .ctrlStrobeN   (ctrlStrobeN),
    .chipEnFirstN  (chipEnFirstN),
    .selValid      (selValid),
    .advanceN      (advanceN),
    .modeInterleave(modeInterleave),
    .addrIn        (addrIn),
    .arrayAddr     (arrayAddr)
  );

  function automatic int expAddr(input logic m);
    int low;
    if (m) low = (refStart % 4) ^ refPos;
    else   low = ((refStart % 4) + refPos) % 4;
    return (refStart - (refStart % 4)) + low;
  endfunction

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input logic r, input logic p, input logic c, input logic ce,
                     input logic s, input logic a, input logic m,
                     input logic [15:0] ad, input string tag);
    bit loadP;
    bit loadC;
    int e;
    rstSync = r; procStrobeN = p; ctrlStrobeN = c; chipEnFirstN = ce;
    selValid = s; advanceN = a; modeInterleave = m; addrIn = ad;
    @(posedge clk);
    loadP = s && !p && !ce;
    loadC = s && !c && p;
    if (r) begin
      refStart = 0; refPos = 0;
    end else if (loadP || loadC) begin
      refStart = int'(ad); refPos = 0;
    end else if (!a) begin
      refPos = (refPos + 1) % 4;
    end
    @(negedge clk);
    e = expAddr(m);
    checks++;
    if (arrayAddr !== 16'(e)) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, arrayAddr, 16'(e));
    end
  endtask

  // idle cycle with advance low or high
  task automatic adv(input logic a, input logic m, input string tag);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, a, m, 16'hFFFF, tag);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, "R11 reset state");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, "R11 reset state");
    // interleaved burst from processor strobe, start low bits 01
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1231, "R1 proc capture");
    for (int i = 0; i < 5; i++) adv(1'b0, 1'b1, "R7 R9 interleaved step");
    // suspend
    adv(1'b1, 1'b1, "R6 suspend hold");
    adv(1'b1, 1'b1, "R6 suspend hold");
    adv(1'b0, 1'b1, "R6 resume step");
    // linear burst from controller strobe
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hABC1, "R2 ctrl capture");
    for (int i = 0; i < 6; i++) adv(1'b0, 1'b0, "R8 R9 linear step");
    // odd and even starts in both orders
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7FFE, "R1 capture start 10");
    for (int i = 0; i < 4; i++) adv(1'b0, 1'b1, "R7 interleaved start 10");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0003, "R2 capture start 11");
    for (int i = 0; i < 5; i++) adv(1'b0, 1'b0, "R8 R9 linear from 11 no carry");
    // both strobes with chip enable low: processor wins (same address either way)
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h5552, "R3 both strobes load");
    adv(1'b0, 1'b1, "R3 step after both");
    // both strobes with chip enable high: nothing loads
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h9999, "R3 gated proc blocks ctrl");
    // processor alone with chip enable high: ignored, advance still works
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h8888, "R4 proc ignored");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8888, "R4 proc ignored hold");
    // controller alone with chip enable high still loads
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4444, "R2 ctrl with ce high");
    // load enable low
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h2222, "R5 unselected proc");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3333, "R5 unselected ctrl");
    // load with advance low
    adv(1'b0, 1'b1, "R6 step before load");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hC0D1, "R10 load beats advance");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC0D2, "R10 ctrl load beats advance");
    adv(1'b0, 1'b0, "R8 step after load");
    adv(1'b0, 1'b1, "R7 mode switch mid burst");
    // reset mid burst
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R11 reset mid burst");
    adv(1'b0, 1'b1, "R11 step from zero");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule